// File: doc/BRIEF.md
# SD/MMC Host Command and Response Unit

This unit is the command half of an SD/MMC host controller. Host software builds a 32-bit command argument from two 16-bit register writes, then writes a 16-bit command word. That write launches the command toward the card interface: the unit latches the index, response type, busy flag, command kind and data direction, and raises a one-cycle issue strobe. An addressed data-transfer command also strobes a data-start signal, so the separate data path can reset its buffer pointers.

The card side is a plain byte stream. Response bytes arrive with a valid strobe, and an end strobe closes the command. An end with no bytes means the card did not answer. The unit packs the bytes into eight 16-bit response registers, last word first. It checks the leading four bytes according to the response type and sets bits in a write-one-to-clear status register. The interrupt line is the OR of status AND interrupt-enable. The unit also holds a command-timeout value for use by other logic.

Top module: `sd_cmd_unit`

## Requirements
- R1: A host write to address 0 while no command is active latches the command word. Fields: index = bits 5:0, response type = bits 10:8, busy flag = bit 11, command kind = bits 13:12, direction = bit 15. `cmd_issue` pulses for exactly one cycle and `cmd_active` stays high until `card_rsp_end`. A command write while `cmd_active` is high is ignored.
- R2: Address 1 replaces argument bits 15:0 and address 2 replaces bits 31:16; the other half is kept. `cmd_arg` shows the argument latched at issue and holds it while the command is active.
- R3: Command kind 3 (addressed data transfer) pulses `data_start` together with `cmd_issue`. Other kinds leave it low.
- R4: Issuing a command clears all eight response registers (addresses 8 to 15) to zero.
- R5: The k-th response byte (k from 0, in arrival order) goes into response register 7 − k/2. An even k fills the upper 8 bits and an odd k fills the lower 8 bits. Bytes after the sixteenth are dropped.
- R6: A completion with zero bytes and a response type other than 0 sets status bit 7 (timeout). Type 0 never sets it.
- R7: Every completion sets status bit 0. A response type of 1 with the busy flag set (R1b) also sets bit 2. The busy flag has no effect with any other type.
- R8: For types 1 and 1b with bytes received, the first four bytes are read as a big-endian word. If that word AND 0xFDF80000 is nonzero, status bit 14 is set.
- R9: For type 3 with bytes received, status bit 12 is set when bit 31 of that word is clear.
- R10: For type 6 with bytes received, status bit 14 is set when bits 15:13 of that word (from bytes 2 and 3) are nonzero.
- R11: Status is read at address 3. Writing a 1 to a bit clears it. A completion in the same cycle as a clear write wins.
- R12: The interrupt enable is at address 4. `irq` is high one cycle after (status AND enable) becomes nonzero, and low one cycle after it becomes zero.
- R13: The timeout register at address 5 stores the low 8 bits of a write. Writes of 0xFE or 0xFF leave it unchanged.
- R14: Response registers are read-only; host writes to them have no effect. Every read returns its data on `host_rdata` in the cycle after `host_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | ADDR_W (4) | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Registered read data |
| cmd_issue | output | 1 | One-cycle command launch strobe |
| cmd_active | output | 1 | Command awaiting card completion |
| cmd_index | output | 6 | Latched command index |
| cmd_rsp_type | output | 3 | Latched response type |
| cmd_kind | output | 2 | Latched command kind |
| cmd_dir | output | 1 | Latched data direction |
| cmd_arg | output | 32 | Argument latched at issue |
| data_start | output | 1 | Data-transfer start strobe |
| card_byte_valid | input | 1 | Response byte valid |
| card_byte | input | 8 | Response byte |
| card_rsp_end | input | 1 | End of card response |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the card interface only sends bytes and end strobes while a command is active. They also assume that a byte and an end strobe never fall in the same cycle; the design drops a byte that shares a cycle with an end strobe. The stimulus drives each byte in its own cycle and the end strobe in a separate cycle after the last byte. It leaves both strobes low when no command is outstanding. Host writes and reads happen one at a time, except for one deliberate collision between a status clear and a completion.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam logic [2:0] RT_NONE = 3'd0;
  localparam logic [2:0] RT_R1   = 3'd1;
  localparam logic [2:0] RT_R2   = 3'd2;
  localparam logic [2:0] RT_R3   = 3'd3;
  localparam logic [2:0] RT_R6   = 3'd6;

  localparam logic [1:0] KIND_DATA = 2'd3;

  // card status error bits checked for R1/R1b, and upper bits for R6
  localparam logic [31:0] R1_ERR_MASK = 32'hFDF8_0000;
  localparam logic [15:0] R6_ERR_MASK = 16'hE000;

  localparam int ST_END      = 0;
  localparam int ST_BUSY_END = 2;
  localparam int ST_TIMEOUT  = 7;
  localparam int ST_OCR_BUSY = 12;
  localparam int ST_CARD_ERR = 14;

  localparam int A_CMD   = 0;
  localparam int A_ARGLO = 1;
  localparam int A_ARGHI = 2;
  localparam int A_STAT  = 3;
  localparam int A_IEN   = 4;
  localparam int A_CTO   = 5;

  typedef struct packed {
    logic       dir;
    logic [1:0] kind;
    logic       rbusy;
    logic [2:0] rtype;
    logic [5:0] idx;
  } cmd_fields_t;
endpackage

// File: rtl/sd_cmd_decode.sv
module sd_cmd_decode
  import sd_cmd_pkg::*;
(
  input  logic [15:0] word,
  output cmd_fields_t f
);
  logic unused_bits;
  assign unused_bits = ^{word[14], word[7:6]};

  always_comb begin
    f.dir   = word[15];
    f.kind  = word[13:12];
    f.rbusy = word[11];
    f.rtype = word[10:8];
    f.idx   = word[5:0];
  end
endmodule

// File: rtl/sd_rsp_eval.sv
module sd_rsp_eval
  import sd_cmd_pkg::*;
(
  input  logic [2:0]  rtype,
  input  logic        rbusy,
  input  logic        got_none,
  input  logic [31:0] word,
  output logic [15:0] set_bits
);
  always_comb begin
    set_bits = '0;
    set_bits[ST_END] = 1'b1;
    if (rtype == RT_R1 && rbusy)
      set_bits[ST_BUSY_END] = 1'b1;
    if (got_none) begin
      if (rtype != RT_NONE)
        set_bits[ST_TIMEOUT] = 1'b1;
    end else begin
      case (rtype)
        RT_R1:   if (|(word & R1_ERR_MASK)) set_bits[ST_CARD_ERR] = 1'b1;
        RT_R3:   if (!word[31]) set_bits[ST_OCR_BUSY] = 1'b1;
        RT_R6:   if (|(word[15:0] & R6_ERR_MASK)) set_bits[ST_CARD_ERR] = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sd_rsp_store.sv
module sd_rsp_store #(
  parameter int WORDS = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        we,
  input  logic [$clog2(2*WORDS)-1:0]  bidx,
  input  logic [7:0]                  bdata,
  input  logic [$clog2(WORDS)-1:0]    ridx,
  output logic [15:0]                 rword
);
  localparam int WW = $clog2(WORDS);
  localparam int BW = $clog2(2*WORDS);

  logic [15:0]   mem [WORDS];
  logic [WW-1:0] widx;
  logic          any_nz;

  // reverse word order: first bytes land in the highest register
  assign widx  = WW'(WORDS-1) - bidx[BW-1:1];
  assign rword = mem[ridx];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (we) begin
      if (bidx[0]) mem[widx] <= {mem[widx][15:8], bdata};
      else         mem[widx] <= {bdata, mem[widx][7:0]};
    end
  end

  always_comb begin
    any_nz = 1'b0;
    for (int i = 0; i < WORDS; i++) any_nz = any_nz | (|mem[i]);
  end

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clr |=> !any_nz); // R4
endmodule

// File: rtl/sd_cmd_unit.sv
module sd_cmd_unit
  import sd_cmd_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CTO_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              cmd_issue,
  output logic              cmd_active,
  output logic [5:0]        cmd_index,
  output logic [2:0]        cmd_rsp_type,
  output logic [1:0]        cmd_kind,
  output logic              cmd_dir,
  output logic [31:0]       cmd_arg,
  output logic              data_start,
  input  logic              card_byte_valid,
  input  logic [7:0]        card_byte,
  input  logic              card_rsp_end,
  output logic              irq
);
  localparam int RSP_WORDS = 2**(ADDR_W-1);
  localparam int NBYTES    = 2*RSP_WORDS;
  localparam int CNTW      = $clog2(NBYTES+1);
  localparam int BIDXW     = $clog2(NBYTES);
  localparam int RIDXW     = ADDR_W-1;
  localparam logic [CTO_W-1:0] CTO_RSV_A = '1;
  localparam logic [CTO_W-1:0] CTO_RSV_B = {{(CTO_W-1){1'b1}}, 1'b0};

  logic [15:0]      cmd_raw_q;
  logic [31:0]      arg_q, arg_lat_q, word_q;
  logic             active_q, issue_q, dstart_q, irq_q;
  logic [CNTW-1:0]  cnt_q;
  logic [15:0]      stat_q, stat_n, ien_q, rdata_q, rd_mux, set_bits, rsp_word;
  logic [CTO_W-1:0] cto_q, cto_wr;
  cmd_fields_t      cur_f;
  logic             wr_cmd, done, take_byte, wr_stat;

  assign wr_cmd    = host_wr && host_addr == ADDR_W'(A_CMD) && !active_q;
  assign wr_stat   = host_wr && host_addr == ADDR_W'(A_STAT);
  assign done      = active_q && card_rsp_end;
  assign take_byte = active_q && card_byte_valid && !card_rsp_end
                     && (cnt_q < CNTW'(NBYTES));
  assign cto_wr    = host_wdata[CTO_W-1:0];

  sd_cmd_decode u_dec (
    .word (cmd_raw_q),
    .f    (cur_f)
  );

  sd_rsp_eval u_eval (
    .rtype    (cur_f.rtype),
    .rbusy    (cur_f.rbusy),
    .got_none (cnt_q == '0),
    .word     (word_q),
    .set_bits (set_bits)
  );

  sd_rsp_store #(.WORDS(RSP_WORDS)) u_store (
    .clk   (clk),
    .rst   (rst),
    .clr   (wr_cmd),
    .we    (take_byte),
    .bidx  (cnt_q[BIDXW-1:0]),
    .bdata (card_byte),
    .ridx  (host_addr[RIDXW-1:0]),
    .rword (rsp_word)
  );

  always_comb begin
    stat_n = stat_q;
    if (wr_stat) stat_n = stat_n & ~host_wdata;
    if (done)    stat_n = stat_n | set_bits;
  end

  always_comb begin
    rd_mux = '0;
    if (host_addr[ADDR_W-1]) rd_mux = rsp_word;
    else begin
      case (int'(host_addr))
        A_CMD:   rd_mux = cmd_raw_q;
        A_ARGLO: rd_mux = arg_q[15:0];
        A_ARGHI: rd_mux = arg_q[31:16];
        A_STAT:  rd_mux = stat_q;
        A_IEN:   rd_mux = ien_q;
        A_CTO:   rd_mux = 16'(cto_q);
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_raw_q <= '0;
      arg_q     <= '0;
      arg_lat_q <= '0;
      word_q    <= '0;
      active_q  <= 1'b0;
      issue_q   <= 1'b0;
      dstart_q  <= 1'b0;
      irq_q     <= 1'b0;
      cnt_q     <= '0;
      stat_q    <= '0;
      ien_q     <= '0;
      cto_q     <= '0;
      rdata_q   <= '0;
    end else begin
      issue_q  <= wr_cmd;
      dstart_q <= wr_cmd && host_wdata[13:12] == KIND_DATA;
      stat_q   <= stat_n;
      irq_q    <= |(stat_q & ien_q);
      if (host_rd) rdata_q <= rd_mux;
      if (host_wr && host_addr == ADDR_W'(A_ARGLO)) arg_q[15:0]  <= host_wdata;
      if (host_wr && host_addr == ADDR_W'(A_ARGHI)) arg_q[31:16] <= host_wdata;
      if (host_wr && host_addr == ADDR_W'(A_IEN))   ien_q        <= host_wdata;
      if (host_wr && host_addr == ADDR_W'(A_CTO)
          && cto_wr != CTO_RSV_A && cto_wr != CTO_RSV_B)
        cto_q <= cto_wr;
      if (wr_cmd) begin
        cmd_raw_q <= host_wdata;
        arg_lat_q <= arg_q;
        active_q  <= 1'b1;
        cnt_q     <= '0;
        word_q    <= '0;
      end else begin
        if (done) active_q <= 1'b0;
        if (take_byte) begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q < CNTW'(4)) word_q <= {word_q[23:0], card_byte};
        end
      end
    end
  end

  assign host_rdata   = rdata_q;
  assign cmd_issue    = issue_q;
  assign cmd_active   = active_q;
  assign cmd_index    = cur_f.idx;
  assign cmd_rsp_type = cur_f.rtype;
  assign cmd_kind     = cur_f.kind;
  assign cmd_dir      = cur_f.dir;
  assign cmd_arg      = arg_lat_q;
  assign data_start   = dstart_q;
  assign irq          = irq_q;

  AST_ISSUE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    cmd_issue |=> !cmd_issue); // R1
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (active_q && host_wr && host_addr == ADDR_W'(A_CMD)) |=> $stable(cmd_raw_q)); // R1
  AST_ARG_HELD: assert property (@(posedge clk) disable iff (rst)
    active_q |=> $stable(cmd_arg)); // R2
  AST_DATA_WITH_ISSUE: assert property (@(posedge clk) disable iff (rst)
    data_start |-> cmd_issue); // R3
  AST_TIMEOUT_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (done && cnt_q != '0 && !stat_q[ST_TIMEOUT]) |=> !stat_q[ST_TIMEOUT]); // R6
  AST_END_FLAG: assert property (@(posedge clk) disable iff (rst)
    done |=> stat_q[ST_END]); // R7
  AST_CTO_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cto_q != CTO_RSV_A && cto_q != CTO_RSV_B); // R13
endmodule

// File: tb/tb_sd_cmd_unit.sv
module tb_sd_cmd_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        cmd_issue, cmd_active, cmd_dir, data_start, irq;
  logic [5:0]  cmd_index;
  logic [2:0]  cmd_rsp_type;
  logic [1:0]  cmd_kind;
  logic [31:0] cmd_arg;
  logic        card_byte_valid = 1'b0, card_rsp_end = 1'b0;
  logic [7:0]  card_byte = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sd_cmd_unit dut (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .cmd_issue(cmd_issue), .cmd_active(cmd_active), .cmd_index(cmd_index),
    .cmd_rsp_type(cmd_rsp_type), .cmd_kind(cmd_kind), .cmd_dir(cmd_dir),
    .cmd_arg(cmd_arg), .data_start(data_start),
    .card_byte_valid(card_byte_valid), .card_byte(card_byte),
    .card_rsp_end(card_rsp_end), .irq(irq)
  );

  // {rtype[2:0], busy, nbytes[4:0], first word[31:0], expected status[15:0]}
  localparam logic [56:0] VEC [13] = '{
    {3'd1, 1'b0, 5'd6,  32'h0000_0900, 16'h0001},  // R8 clean
    {3'd1, 1'b0, 5'd6,  32'h8000_0000, 16'h4001},  // R8 out of range
    {3'd1, 1'b1, 5'd6,  32'h0008_0000, 16'h4005},  // R7 R8 R1b generic error
    {3'd1, 1'b1, 5'd6,  32'h0200_0000, 16'h0005},  // R7 R8 unmasked bit
    {3'd2, 1'b0, 5'd16, 32'hFFFF_FFFF, 16'h0001},  // R5 full R2
    {3'd3, 1'b0, 5'd6,  32'h00FF_8000, 16'h1001},  // R9 busy clear
    {3'd3, 1'b0, 5'd6,  32'h80FF_8000, 16'h0001},  // R9 ready
    {3'd6, 1'b0, 5'd6,  32'h1234_2000, 16'h4001},  // R10 error bit
    {3'd6, 1'b0, 5'd6,  32'h1234_1F00, 16'h0001},  // R10 clean
    {3'd1, 1'b0, 5'd0,  32'h0000_0000, 16'h0081},  // R6 timeout
    {3'd0, 1'b0, 5'd0,  32'h0000_0000, 16'h0001},  // R6 none expected
    {3'd3, 1'b1, 5'd6,  32'h8000_0000, 16'h0001},  // R7 busy ignored
    {3'd2, 1'b0, 5'd18, 32'h0102_0304, 16'h0001}   // R5 overflow bytes
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  function automatic logic [7:0] gen(input int k, input logic [31:0] w);
    if (k < 4) return w[31-8*k -: 8];
    return 8'((k*29 + 7) & 255);
  endfunction

  function automatic logic [15:0] exp_rsp(input int j, input int n, input logic [31:0] w);
    int k = 2*(7-j);
    logic [15:0] r = '0;
    if (k < n)     r[15:8] = gen(k, w);
    if (k + 1 < n) r[7:0]  = gen(k+1, w);
    return r;
  endfunction

  task automatic feed(input int n, input logic [31:0] w);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      card_byte_valid = 1'b1; card_byte = gen(k, w);
    end
    @(negedge clk);
    card_byte_valid = 1'b0; card_rsp_end = 1'b1;
    @(negedge clk);
    card_rsp_end = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [56:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    rd(4'd3, d);  check("R11 reset status", d, 16'h0);
    rd(4'd4, d);  check("R12 reset enable", d, 16'h0);
    rd(4'd5, d);  check("R13 reset timeout reg", d, 16'h0);
    rd(4'd12, d); check("R4 reset response", d, 16'h0);
    check("R12 reset irq", irq, 0);
    check("R1 reset active", cmd_active, 0);

    // argument assembly and field decode
    wr(4'd1, 16'hBEEF);
    wr(4'd2, 16'hDEAD);
    wr(4'd0, 16'hB011);
    check("R1 issue pulse", cmd_issue, 1);
    check("R1 index", cmd_index, 17);
    check("R1 dir", cmd_dir, 1);
    check("R1 kind", cmd_kind, 3);
    check("R1 rsp type", cmd_rsp_type, 0);
    check("R3 data start", data_start, 1);
    check("R2 arg", cmd_arg, 32'hDEADBEEF);
    @(negedge clk);
    check("R1 pulse ends", cmd_issue, 0);
    check("R1 active held", cmd_active, 1);
    feed(0, 0);
    check("R1 active drops", cmd_active, 0);

    wr(4'd1, 16'h1234);
    rd(4'd2, d); check("R2 high half kept", d, 16'hDEAD);
    rd(4'd1, d); check("R2 low half", d, 16'h1234);
    wr(4'd0, 16'h1105);
    check("R3 no data start", data_start, 0);
    check("R2 partial arg", cmd_arg, 32'hDEAD1234);
    wr(4'd0, 16'h0009);
    check("R1 busy write ignored", cmd_index, 5);
    rd(4'd0, d); check("R1 cmd readback", d, 16'h1105);
    feed(0, 0);
    rd(4'd3, d); check("R6 timeout status", d, 16'h0081);
    wr(4'd3, 16'h0001);
    rd(4'd3, d); check("R11 clear bit0 only", d, 16'h0080);
    wr(4'd3, 16'h0080);
    rd(4'd3, d); check("R11 all cleared", d, 16'h0000);

    // vector table
    wr(4'd4, 16'hFFFF);
    for (int i = 0; i < 13; i++) begin
      int n;
      v = VEC[i];
      n = int'(v[52:48]);
      wr(4'd0, {1'b0, 1'b0, 2'b00, v[53], v[56:54], 2'b00, 6'(i+1)});
      check("R1 vec issue", cmd_issue, 1);
      check("R3 vec no data start", data_start, 0);
      check("R1 vec rsp type", cmd_rsp_type, v[56:54]);
      feed(n, v[47:16]);
      rd(4'd3, d); check("R6 R7 R8 R9 R10 vec status", d, v[15:0]);
      for (int j = 0; j < 8; j++) begin
        rd(4'(8+j), d);
        check("R5 vec response", d, exp_rsp(j, n, v[47:16]));
      end
      check("R12 vec irq high", irq, 1);
      wr(4'd3, 16'hFFFF);
      @(negedge clk);
      check("R12 vec irq low", irq, 0);
    end

    // interrupt masking
    wr(4'd4, 16'h0002);
    wr(4'd0, 16'h0100);
    feed(6, 32'h8000_0000);
    rd(4'd3, d); check("R8 error status", d, 16'h4001);
    check("R12 masked irq", irq, 0);
    wr(4'd4, 16'h4000);
    @(negedge clk);
    check("R12 enabled irq", irq, 1);
    wr(4'd3, 16'hFFFF);

    // read-only response registers and clear on issue
    wr(4'd0, 16'h0200);
    feed(16, 32'hA1B2_C3D4);
    wr(4'd15, 16'hFFFF);
    rd(4'd15, d); check("R14 response write ignored", d, 16'hA1B2);
    wr(4'd0, 16'h0000);
    rd(4'd15, d); check("R4 cleared on issue", d, 16'h0000);
    rd(4'd8, d);  check("R4 cleared last word", d, 16'h0000);
    feed(0, 0);
    wr(4'd3, 16'hFFFF);

    // completion beats a simultaneous clear
    wr(4'd0, 16'h0000);
    @(negedge clk);
    card_rsp_end = 1'b1; host_wr = 1'b1; host_addr = 4'd3; host_wdata = 16'hFFFF;
    @(negedge clk);
    card_rsp_end = 1'b0; host_wr = 1'b0;
    rd(4'd3, d); check("R11 set wins", d, 16'h0001);

    // timeout register
    wr(4'd5, 16'h0123);
    rd(4'd5, d); check("R13 low byte kept", d, 16'h0023);
    wr(4'd5, 16'h00FE);
    rd(4'd5, d); check("R13 0xFE ignored", d, 16'h0023);
    wr(4'd5, 16'h00FF);
    rd(4'd5, d); check("R13 0xFF ignored", d, 16'h0023);
    wr(4'd5, 16'h007D);
    rd(4'd5, d); check("R13 new value", d, 16'h007D);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule